// File: doc/BRIEF.md
# Dual-Channel Register-Programmed PWM Generator

This block produces up to two pulse-width-modulated outputs from one system clock. Software sets it up through a small word-addressed register bus. A shared control word holds one field per channel. Each field chooses a clock divisor from a fixed table, sets an enable, sets a run gate and sets the output polarity. Each channel also has its own word that holds its period and its duty count.

Each channel derives a tick from the divisor and advances a period counter on every tick. The output is at its active level while the counter is below the duty count. A new period/duty word is held in a shadow copy and takes effect at the next period boundary, so the running waveform never shows a torn period. A per-channel ready flag in the control word tells software that a staged value has not yet been applied.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset, the control word and both period/duty words read 0. Every output sits at logic 1, which is the idle level when the polarity bit is 0.
- R2: Word 0x0 is the control word. Channel n uses bits [15n+6:15n] of it: [3:0] divisor code, bit 4 enable, bit 5 active level, bit 6 run gate. The period/duty word of channel n is at 0x4+4n, with [31:16] holding the period minus one and [15:0] holding the duty count. Both kinds of word read back the last value written.
- R3: Divisor codes 0..4 give 120, 180, 240, 360 and 480 clocks per tick. Codes 8..12 give 12000, 24000, 36000, 48000 and 72000 clocks per tick. When BYPASS_EN is 1, code 15 gives 1 clock per tick.
- R4: Codes 5..7 and 13..14 are invalid, and so is code 15 when BYPASS_EN is 0. A channel with an invalid code keeps its output at the idle level.
- R5: A channel runs only when its enable bit and its run-gate bit are both 1. Otherwise its output is the inverse of its active-level bit, and its counters are held at zero.
- R6: A running channel repeats a period of (period field + 1) ticks. It drives the active-level bit value while the count is below the duty count and the opposite level for the rest of the period.
- R7: A duty count of 0 gives a constant idle output. A duty count equal to or above the period gives a constant active output.
- R8: A period/duty write to a running channel takes effect at the next period boundary. Control bit 28+n reads 1 from the write until that boundary. A write to an idle channel is applied on the next clock.
- R9: The channels count and drive their outputs independently of each other.
- R10: Writes to ready bits 28+n and to unmapped word addresses change nothing. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one clock per write |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The in-module assertions check on every clock that the period counter never passes the period field. They also check that the ready flag clears only at a boundary or while the channel is idle, and that the applied period and duty stay stable inside a period. Two more checks are that a zero duty keeps the output idle, and that the divider counter is zero on the clock after a gated or disabled cycle. Only the bench scenarios can show the absolute divisor values, the count of active cycles for each polarity and duty corner, the inverted idle level, and independent operation of the two channels. The same applies to the bus-side effects: readback, ignored writes and ready-flag timing.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;
  localparam int PSC_W      = 17;  // holds 72000
  localparam int FLD_W      = 7;
  localparam int FLD_STRIDE = 15;
  localparam int RDY_BASE   = 28;
  localparam int CNT_W      = 16;

  // field bit positions inside a channel field
  localparam int F_EN   = 4;
  localparam int F_ACT  = 5;
  localparam int F_GATE = 6;

  // clocks per tick; 0 marks an invalid code
  function automatic logic [PSC_W-1:0] psc_div(input logic [3:0] code, input logic bypass);
    logic [PSC_W-1:0] d;
    case (code)
      4'd0:  d = PSC_W'(120);
      4'd1:  d = PSC_W'(180);
      4'd2:  d = PSC_W'(240);
      4'd3:  d = PSC_W'(360);
      4'd4:  d = PSC_W'(480);
      4'd8:  d = PSC_W'(12000);
      4'd9:  d = PSC_W'(24000);
      4'd10: d = PSC_W'(36000);
      4'd11: d = PSC_W'(48000);
      4'd12: d = PSC_W'(72000);
      4'd15: d = bypass ? PSC_W'(1) : '0;
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pwm_ctrl_psc.sv
module pwm_ctrl_psc
  import pwm_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic             last;

  // >= so a divisor shrink while running still wraps
  assign last   = psc_q >= (div_i - PSC_W'(1));
  assign tick_o = run_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      psc_q <= '0;
    else if (!run_i)  psc_q <= '0;
    else if (last)    psc_q <= '0;
    else              psc_q <= psc_q + PSC_W'(1);
  end

  // R5
  psc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (psc_q == '0));
endmodule

// File: rtl/pwm_ctrl_chan.sv
module pwm_ctrl_chan
  import pwm_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        tick_i,
  input  logic        act_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        pwm_o,
  output logic        pend_o,
  output logic [31:0] shadow_o
);
  logic [CNT_W-1:0] prd_q, dty_q, cnt_q;
  logic [31:0]      shadow_q;
  logic             pend_q;
  logic             wrap;
  logic             in_duty;

  assign wrap    = run_i & tick_i & (cnt_q >= prd_q);
  assign in_duty = cnt_q < dty_q;

  // staged word; applied at boundary, or at once when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      prd_q    <= '0;
      dty_q    <= '0;
    end else if (wr_i) begin
      shadow_q <= wdata_i;
      pend_q   <= 1'b1;
    end else if (pend_q && (!run_i || wrap)) begin
      prd_q  <= shadow_q[31:16];
      dty_q  <= shadow_q[15:0];
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign pwm_o    = (run_i && in_duty) ? act_i : ~act_i;
  assign pend_o   = pend_q;
  assign shadow_o = shadow_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= prd_q);

  // R8
  rdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(!run_i || wrap));

  // R8
  cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(wrap)) |-> ($stable(prd_q) && $stable(dty_q)));

  // R7
  duty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && dty_q == '0) |-> (pwm_o == ~act_i));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int NUM_CH    = 2,  // 1 or 2
  parameter bit BYPASS_EN = 1'b1,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]             idx;
  logic                         ctrl_we;
  logic [NUM_CH-1:0][FLD_W-1:0] fld_q;
  logic [NUM_CH-1:0][31:0]      shadow;
  logic [NUM_CH-1:0]            pend;

  assign idx     = bus_addr_i[ADDR_W-1:2];
  assign ctrl_we = bus_we_i && (idx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q <= '0;
    end else if (ctrl_we) begin
      for (int c = 0; c < NUM_CH; c++)
        fld_q[c] <= bus_wdata_i[c*FLD_STRIDE +: FLD_W];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [PSC_W-1:0] div;
    logic             run;
    logic             tick;

    assign div = psc_div(fld_q[ch][3:0], BYPASS_EN);
    assign run = fld_q[ch][F_EN] & fld_q[ch][F_GATE] & (div != '0);

    pwm_ctrl_psc u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .div_i  (div),
      .tick_o (tick)
    );

    pwm_ctrl_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .tick_i   (tick),
      .act_i    (fld_q[ch][F_ACT]),
      .wr_i     (bus_we_i && (idx == IDX_W'(ch + 1))),
      .wdata_i  (bus_wdata_i),
      .pwm_o    (pwm_o[ch]),
      .pend_o   (pend[ch]),
      .shadow_o (shadow[ch])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (idx == '0) begin
      for (int c = 0; c < NUM_CH; c++) begin
        bus_rdata_o[c*FLD_STRIDE +: FLD_W] = fld_q[c];
        bus_rdata_o[RDY_BASE + c]          = pend[c];
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (idx == IDX_W'(c + 1)) bus_rdata_o = shadow[c];
    end
  end
endmodule

// File: tb/pwm_ctrl_tb.sv
module pwm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_ctrl #(.NUM_CH(2), .BYPASS_EN(1'b1), .ADDR_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pwm_o(pwm)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic        en;
    logic        gate;
    logic        act;
    logic [15:0] pm1;
    logic [15:0] dty;
    logic [31:0] win;
    logic [31:0] highs;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{4'd15, 1'b1, 1'b1, 1'b1, 16'd9, 16'd3,     32'd40,    32'd12,    8'd6},  // R6 normal
    '{4'd15, 1'b1, 1'b1, 1'b0, 16'd9, 16'd3,     32'd40,    32'd28,    8'd6},  // R6 inverted
    '{4'd15, 1'b1, 1'b1, 1'b1, 16'd0, 16'd1,     32'd4,     32'd4,     8'd6},  // R6 period 1
    '{4'd0,  1'b1, 1'b1, 1'b1, 16'd3, 16'd1,     32'd1920,  32'd480,   8'd3},  // R3 /120
    '{4'd1,  1'b1, 1'b1, 1'b1, 16'd1, 16'd1,     32'd1440,  32'd720,   8'd3},  // R3 /180
    '{4'd2,  1'b1, 1'b1, 1'b1, 16'd1, 16'd1,     32'd1920,  32'd960,   8'd3},  // R3 /240
    '{4'd3,  1'b1, 1'b1, 1'b1, 16'd1, 16'd1,     32'd1440,  32'd720,   8'd3},  // R3 /360
    '{4'd4,  1'b1, 1'b1, 1'b1, 16'd1, 16'd1,     32'd1920,  32'd960,   8'd3},  // R3 /480
    '{4'd8,  1'b1, 1'b1, 1'b1, 16'd1, 16'd1,     32'd48000, 32'd24000, 8'd3},  // R3 /12000
    '{4'd15, 1'b1, 1'b1, 1'b1, 16'd7, 16'd0,     32'd32,    32'd0,     8'd7},  // R7 zero duty
    '{4'd15, 1'b1, 1'b1, 1'b1, 16'd7, 16'd8,     32'd32,    32'd32,    8'd7},  // R7 duty=period
    '{4'd15, 1'b1, 1'b1, 1'b0, 16'd7, 16'hFFFF,  32'd32,    32'd0,     8'd7},  // R7 duty max, inverted
    '{4'd5,  1'b1, 1'b1, 1'b1, 16'd7, 16'd3,     32'd32,    32'd0,     8'd4},  // R4 code 5
    '{4'd13, 1'b1, 1'b1, 1'b0, 16'd7, 16'd3,     32'd32,    32'd32,    8'd4},  // R4 code 13
    '{4'd15, 1'b1, 1'b0, 1'b1, 16'd7, 16'd3,     32'd32,    32'd0,     8'd5},  // R5 gate off
    '{4'd15, 1'b0, 1'b1, 1'b0, 16'd7, 16'd3,     32'd32,    32'd32,    8'd5}   // R5 enable off
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic count_hi(input int ch, input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm[ch]) n++;
    end
  endtask

  function automatic logic [6:0] fld(input logic [3:0] code, input logic en, gate, act);
    return {gate, act, en, code};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int n, n1;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    bus_rd(4'h0, rd); chk("R1 ctrl", rd, 32'h0);
    bus_rd(4'h4, rd); chk("R1 word0", rd, 32'h0);
    bus_rd(4'h8, rd); chk("R1 word1", rd, 32'h0);
    chk("R1 outputs", {30'h0, pwm}, 32'h3);

    // vector table on channel 0
    for (int v = 0; v < NV; v++) begin
      bus_wr(4'h0, 32'h0);
      bus_wr(4'h4, {VT[v].pm1, VT[v].dty});
      repeat (2) @(negedge clk);
      bus_wr(4'h0, {25'h0, fld(VT[v].code, VT[v].en, VT[v].gate, VT[v].act)});
      repeat (3) @(negedge clk);
      count_hi(0, int'(VT[v].win), n);
      chk($sformatf("R%0d vector %0d high count", VT[v].req, v), n, VT[v].highs);
    end

    // R2 readback and field layout
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h8, 32'h1234_5678);
    bus_rd(4'h8, rd); chk("R2 word1 readback", rd, 32'h1234_5678);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, rd); chk("R2 ctrl field mask", rd, 32'h003F_807F);
    bus_wr(4'h0, 32'h0);

    // R10 ready bits and unmapped words ignore writes
    bus_wr(4'h0, 32'h3000_0000);
    bus_rd(4'h0, rd); chk("R10 ready bits not writable", rd, 32'h0);
    bus_wr(4'h4, 32'h0009_0003);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'h0, rd); chk("R10 ctrl after unmapped write", rd, 32'h0);
    bus_rd(4'h4, rd); chk("R10 word0 after unmapped write", rd, 32'h0009_0003);
    bus_rd(4'hC, rd); chk("R10 unmapped reads 0", rd, 32'h0);
    chk("R10 outputs idle", {30'h0, pwm}, 32'h3);

    // R8 staging on a running channel
    bus_wr(4'h4, {16'd99, 16'd50});
    bus_rd(4'h0, rd); chk("R8 idle write applied at once", rd[28], 1'b0);
    bus_wr(4'h0, {25'h0, fld(4'd15, 1'b1, 1'b1, 1'b1)});
    repeat (5) @(negedge clk);
    bus_wr(4'h4, {16'd99, 16'd20});
    bus_rd(4'h0, rd); chk("R8 ready set while staged", rd[28], 1'b1);
    bus_rd(4'h4, rd); chk("R8 staged word readback", rd, {16'd99, 16'd20});
    repeat (110) @(negedge clk);
    bus_rd(4'h0, rd); chk("R8 ready clear after boundary", rd[28], 1'b0);
    count_hi(0, 400, n); chk("R8 new duty in effect", n, 32'd80);

    // R9 both channels at once
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h4, {16'd9, 16'd3});
    bus_wr(4'h8, {16'd9, 16'd7});
    bus_wr(4'h0, {10'h0, fld(4'd15, 1'b1, 1'b1, 1'b1), 8'h0, fld(4'd15, 1'b1, 1'b1, 1'b1)});
    repeat (3) @(negedge clk);
    n = 0; n1 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm[0]) n++;
      if (pwm[1]) n1++;
    end
    chk("R9 channel 0 count", n, 32'd12);
    chk("R9 channel 1 count", n1, 32'd28);
    bus_wr(4'h0, {10'h0, fld(4'd15, 1'b1, 1'b1, 1'b0), 8'h0, 7'h0});
    repeat (3) @(negedge clk);
    count_hi(1, 40, n1); chk("R9 channel 1 polarity alone", n1, 32'd12);
    count_hi(0, 40, n);  chk("R9 channel 0 idle while channel 1 runs", n, 32'd40);

    finish_run();
  end
endmodule